// File: doc/BRIEF.md
# Parallel 4x4 SAD Processing Array

This block is the matching core of a full-search motion estimator. It keeps one 16x16 current macroblock in local registers and compares it with one candidate block of the reference search window in every clock cycle. A grid of 16x16 processing elements forms the 256 per-pixel absolute differences of a candidate at once. The grid then reduces them into sixteen separate sums of absolute differences (SADs), one for each 4x4 sub-block. Larger partitions (8x4, 8x8, 16x16 and so on) can be built from these sums downstream, so one pass over the search window serves every block size.

A start pulse captures the current macroblock and starts the candidate sequencer. The sequencer walks a 32x32 grid of candidate offsets in raster order, one offset per cycle, with no gaps. For each offset it drives a read request to sixteen search-window banks, one bank per candidate row, which all answer in parallel. The sixteen 4x4 SADs of each candidate leave the block with a valid flag and the candidate's index. A done pulse travels with the last candidate.

Top module: `sad4x4_array`

## Requirements
- R1: While reset is held and afterwards, until a start is accepted, `rd_en_o`, `sad_vld_o` and `done_o` stay low.
- R2: A start pulse accepted while the block is idle captures `cur_blk_i`. In the next cycle `rd_en_o` is high with `cand_x_o` = 0 and `cand_y_o` = 0. Current pixel (row r, column c) sits at bits [(r*16+c)*8 +: 8].
- R3: After a start, `rd_en_o` stays high for exactly 1024 consecutive cycles. The offsets follow raster order: `cand_x_o` counts 0..31 fastest, then `cand_y_o` advances. The candidate index is `cand_y_o`*32 + `cand_x_o`.
- R4: The block expects `ref_rows_i` one cycle after the request it answers. Bank r carries the 16 reference pixels of candidate row r: pixel (r, c) of the candidate at offset (y, x) is window pixel (y+r, x+c), at bits [(r*16+c)*8 +: 8].
- R5: Lane s of `sad_o` (bits [s*12 +: 12], s = 4*block_row + block_col) equals the sum over the 4x4 sub-block of |current - candidate|. A candidate identical to the current block gives zero in every lane.
- R6: The result of the candidate requested in cycle t appears in cycle t+3, with `sad_vld_o` high and `sad_idx_o` equal to that candidate's index. Results leave in request order.
- R7: `done_o` is high for exactly one cycle per run: together with the result of index 1023, and never without `sad_vld_o`.
- R8: Each lane holds the largest possible 4x4 SAD, 16*255 = 4080, without wrapping.
- R9: A start pulse that arrives while a run is still requesting or in flight is ignored. The candidate sequence continues unchanged and the captured block is kept.
- R10: Changes on `cur_blk_i` after the accepted start have no effect on the results of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; captures the current macroblock when idle |
| cur_blk_i | input | 2048 | Current macroblock, 256 pixels of 8 bits |
| rd_en_o | output | 1 | Search-window read request, one candidate per cycle |
| cand_x_o | output | 5 | Horizontal offset of the requested candidate |
| cand_y_o | output | 5 | Vertical offset of the requested candidate |
| ref_rows_i | input | 2048 | Sixteen bank outputs, 16 pixels each, one cycle after the request |
| sad_vld_o | output | 1 | Result valid |
| sad_idx_o | output | 10 | Candidate index of the result |
| sad_o | output | 192 | Sixteen 12-bit 4x4 SADs |
| done_o | output | 1 | Marks the result of the final candidate |

## Verification
The checker tests on every cycle the properties that hold on every run: the raster step of the requested offsets, and the fixed three-cycle distance between a request and its result, including the matching index. It also tests that a start during a run never resets the sequence, that every lane stays within the 4080 ceiling, and that the done pulse is tied to the last index. Only the bench's scenarios can show the arithmetic itself. They sweep every candidate of the window under a mixed pattern, an all-maximum difference and a planted exact match. They also show that a late start and a changing current-block input leave the results untouched, because that needs sums computed independently from the pixel patterns.

// File: rtl/sadarr_pkg.sv
// Shared constants and width helpers for the 4x4 SAD array.
// Assumes sub-blocks are square and tile the macroblock exactly.
package sadarr_pkg;

    localparam int unsigned DEF_MB_DIM  = 16;
    localparam int unsigned DEF_SUB_DIM = 4;
    localparam int unsigned DEF_PIX_W   = 8;
    localparam int unsigned DEF_SRCH_W  = 32;
    localparam int unsigned DEF_SRCH_H  = 32;

    // Bits needed to hold the sum of sub_dim*sub_dim absolute differences.
    function automatic int unsigned sad_width(int unsigned pix_w, int unsigned sub_dim);
        return pix_w + $clog2(sub_dim * sub_dim);
    endfunction

    // Largest value a sub-block SAD can reach.
    function automatic int unsigned sad_max(int unsigned pix_w, int unsigned sub_dim);
        return (sub_dim * sub_dim) * ((1 << pix_w) - 1);
    endfunction

endpackage

// File: rtl/sadarr_seq.sv
// Candidate sequencer: after an accepted start, requests every offset of a
// SRCH_W x SRCH_H grid in raster order, one per cycle, without gaps.
// Assumes SRCH_W and SRCH_H are at least 2. A start is accepted only when no
// request is active and the caller reports an empty pipeline.
module sadarr_seq #(
    parameter int unsigned SRCH_W = 32,
    parameter int unsigned SRCH_H = 32,
    parameter int unsigned XW     = 5,
    parameter int unsigned YW     = 5,
    parameter int unsigned IDX_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pipe_busy_i,
    output logic             accept_o,
    output logic             rd_en_o,
    output logic [XW-1:0]    cand_x_o,
    output logic [YW-1:0]    cand_y_o,
    output logic [IDX_W-1:0] cand_idx_o,
    output logic             last_o
);

    logic             act_q;
    logic [XW-1:0]    x_q;
    logic [YW-1:0]    y_q;
    logic [IDX_W-1:0] idx_q;
    logic             x_end;
    logic             y_end;

    // Accept decode and end-of-row / end-of-grid flags.
    always_comb begin
        accept_o = start_i && !act_q && !pipe_busy_i;
        x_end    = (x_q == XW'(SRCH_W - 1));
        y_end    = (y_q == YW'(SRCH_H - 1));
        last_o   = act_q && x_end && y_end;
    end

    // Offset counters and request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            x_q   <= '0;
            y_q   <= '0;
            idx_q <= '0;
        end else if (accept_o) begin
            act_q <= 1'b1;
            x_q   <= '0;
            y_q   <= '0;
            idx_q <= '0;
        end else if (act_q) begin
            idx_q <= idx_q + 1'b1;
            if (x_end) begin
                x_q <= '0;
                if (y_end) begin
                    act_q <= 1'b0;
                    y_q   <= '0;
                    idx_q <= '0;
                end else begin
                    y_q <= y_q + 1'b1;
                end
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    assign rd_en_o    = act_q;
    assign cand_x_o   = x_q;
    assign cand_y_o   = y_q;
    assign cand_idx_o = idx_q;

endmodule

// File: rtl/sadarr_pe.sv
// Processing element: registers the absolute difference of one current
// pixel and one candidate pixel when enabled. Holds its value otherwise.
module sadarr_pe #(
    parameter int unsigned PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PIX_W-1:0] cur_i,
    input  logic [PIX_W-1:0] ref_i,
    output logic [PIX_W-1:0] ad_o
);

    // Absolute difference register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_o <= '0;
        end else if (en_i) begin
            ad_o <= (cur_i > ref_i) ? (cur_i - ref_i) : (ref_i - cur_i);
        end
    end

endmodule

// File: rtl/sadarr_subsum.sv
// Sub-block reducer: adds SUB_N absolute differences into one registered SAD.
// Assumes SAD_W is wide enough for SUB_N maximum-valued differences.
module sadarr_subsum #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned SUB_N = 16,
    parameter int unsigned SAD_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_i,
    input  logic [SUB_N*PIX_W-1:0] ad_i,
    output logic [SAD_W-1:0]       sad_o
);

    logic [SAD_W-1:0] acc;

    // Combinational sum of the sub-block's differences.
    always_comb begin
        acc = '0;
        for (int k = 0; k < SUB_N; k++) begin
            acc = acc + SAD_W'(ad_i[k*PIX_W +: PIX_W]);
        end
    end

    // Result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sad_o <= '0;
        end else if (en_i) begin
            sad_o <= acc;
        end
    end

endmodule

// File: rtl/sad4x4_array.sv
// Parallel SAD array: compares a captured MB_DIM x MB_DIM current block with
// one candidate per cycle and emits one SAD per SUB_DIM x SUB_DIM sub-block.
// Pipeline: request (cycle t), bank data (t+1), difference register (t+2),
// sub-block sums (t+3). Assumes the search banks answer exactly one cycle
// after a request and that MB_DIM is a multiple of SUB_DIM.
module sad4x4_array
    import sadarr_pkg::*;
#(
    parameter int unsigned MB_DIM  = DEF_MB_DIM,
    parameter int unsigned SUB_DIM = DEF_SUB_DIM,
    parameter int unsigned PIX_W   = DEF_PIX_W,
    parameter int unsigned SRCH_W  = DEF_SRCH_W,
    parameter int unsigned SRCH_H  = DEF_SRCH_H
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic [MB_DIM*MB_DIM*PIX_W-1:0]        cur_blk_i,
    output logic                                  rd_en_o,
    output logic [$clog2(SRCH_W)-1:0]             cand_x_o,
    output logic [$clog2(SRCH_H)-1:0]             cand_y_o,
    input  logic [MB_DIM*MB_DIM*PIX_W-1:0]        ref_rows_i,
    output logic                                  sad_vld_o,
    output logic [$clog2(SRCH_W*SRCH_H)-1:0]      sad_idx_o,
    output logic [(MB_DIM/SUB_DIM)*(MB_DIM/SUB_DIM)*sad_width(PIX_W, SUB_DIM)-1:0] sad_o,
    output logic                                  done_o
);

    localparam int unsigned NPIX     = MB_DIM * MB_DIM;
    localparam int unsigned BLK_W    = NPIX * PIX_W;
    localparam int unsigned SPR      = MB_DIM / SUB_DIM;
    localparam int unsigned NUM_SUB  = SPR * SPR;
    localparam int unsigned SUB_N    = SUB_DIM * SUB_DIM;
    localparam int unsigned SAD_W    = sad_width(PIX_W, SUB_DIM);
    localparam int unsigned NUM_CAND = SRCH_W * SRCH_H;
    localparam int unsigned IDX_W    = $clog2(NUM_CAND);
    localparam int unsigned XW       = $clog2(SRCH_W);
    localparam int unsigned YW       = $clog2(SRCH_H);

    logic [BLK_W-1:0] cur_q;
    logic             accept;
    logic             seq_rd;
    logic [IDX_W-1:0] seq_idx;
    logic             seq_last;

    logic             b_vld;
    logic [IDX_W-1:0] b_idx;
    logic             b_last;
    logic             ad_vld;
    logic [IDX_W-1:0] ad_idx;
    logic             ad_last;
    logic [BLK_W-1:0] ad_all;

    sadarr_seq #(
        .SRCH_W (SRCH_W),
        .SRCH_H (SRCH_H),
        .XW     (XW),
        .YW     (YW),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pipe_busy_i (b_vld || ad_vld),
        .accept_o    (accept),
        .rd_en_o     (seq_rd),
        .cand_x_o    (cand_x_o),
        .cand_y_o    (cand_y_o),
        .cand_idx_o  (seq_idx),
        .last_o      (seq_last)
    );

    assign rd_en_o = seq_rd;

    // Current macroblock capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (accept) begin
            cur_q <= cur_blk_i;
        end
    end

    // Valid, index and last-flag tracking along the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_vld     <= 1'b0;
            b_idx     <= '0;
            b_last    <= 1'b0;
            ad_vld    <= 1'b0;
            ad_idx    <= '0;
            ad_last   <= 1'b0;
            sad_vld_o <= 1'b0;
            sad_idx_o <= '0;
            done_o    <= 1'b0;
        end else begin
            b_vld     <= seq_rd;
            b_idx     <= seq_idx;
            b_last    <= seq_last;
            ad_vld    <= b_vld;
            ad_idx    <= b_idx;
            ad_last   <= b_vld && b_last;
            sad_vld_o <= ad_vld;
            sad_idx_o <= ad_idx;
            done_o    <= ad_vld && ad_last;
        end
    end

    // Processing-element grid, one element per pixel position.
    for (genvar r = 0; r < MB_DIM; r++) begin : g_row
        for (genvar c = 0; c < MB_DIM; c++) begin : g_col
            localparam int unsigned P = r * MB_DIM + c;
            sadarr_pe #(.PIX_W(PIX_W)) u_pe (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (b_vld),
                .cur_i (cur_q[P*PIX_W +: PIX_W]),
                .ref_i (ref_rows_i[P*PIX_W +: PIX_W]),
                .ad_o  (ad_all[P*PIX_W +: PIX_W])
            );
        end
    end

    // Sub-block gather and reduction, one reducer per sub-block.
    for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
        localparam int unsigned BR = s / SPR;
        localparam int unsigned BC = s % SPR;
        logic [SUB_N*PIX_W-1:0] grp;
        for (genvar i = 0; i < SUB_DIM; i++) begin : g_i
            for (genvar j = 0; j < SUB_DIM; j++) begin : g_j
                localparam int unsigned SRC = (BR*SUB_DIM + i) * MB_DIM + BC*SUB_DIM + j;
                assign grp[(i*SUB_DIM + j)*PIX_W +: PIX_W] = ad_all[SRC*PIX_W +: PIX_W];
            end
        end
        sadarr_subsum #(
            .PIX_W (PIX_W),
            .SUB_N (SUB_N),
            .SAD_W (SAD_W)
        ) u_sum (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (ad_vld),
            .ad_i  (grp),
            .sad_o (sad_o[s*SAD_W +: SAD_W])
        );
    end

endmodule

// File: rtl/sad4x4_array_chk.sv
// Checker for sad4x4_array: watches the top-level ports only and is attached
// by the bind statement at the end of this file.
module sad4x4_array_chk
    import sadarr_pkg::*;
#(
    parameter int unsigned MB_DIM  = DEF_MB_DIM,
    parameter int unsigned SUB_DIM = DEF_SUB_DIM,
    parameter int unsigned PIX_W   = DEF_PIX_W,
    parameter int unsigned SRCH_W  = DEF_SRCH_W,
    parameter int unsigned SRCH_H  = DEF_SRCH_H
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic                                  rd_en_o,
    input  logic [$clog2(SRCH_W)-1:0]             cand_x_o,
    input  logic [$clog2(SRCH_H)-1:0]             cand_y_o,
    input  logic                                  sad_vld_o,
    input  logic [$clog2(SRCH_W*SRCH_H)-1:0]      sad_idx_o,
    input  logic [(MB_DIM/SUB_DIM)*(MB_DIM/SUB_DIM)*sad_width(PIX_W, SUB_DIM)-1:0] sad_o,
    input  logic                                  done_o
);

    localparam int unsigned NUM_SUB  = (MB_DIM / SUB_DIM) * (MB_DIM / SUB_DIM);
    localparam int unsigned SAD_W    = sad_width(PIX_W, SUB_DIM);
    localparam int unsigned SAD_MAX  = sad_max(PIX_W, SUB_DIM);
    localparam int unsigned NUM_CAND = SRCH_W * SRCH_H;
    localparam int unsigned XW       = $clog2(SRCH_W);
    localparam int unsigned YW       = $clog2(SRCH_H);
    localparam int unsigned IDX_W    = $clog2(NUM_CAND);

    function automatic logic lanes_in_range(input logic [NUM_SUB*SAD_W-1:0] v);
        for (int s = 0; s < NUM_SUB; s++) begin
            if (v[s*SAD_W +: SAD_W] > SAD_W'(SAD_MAX)) return 1'b0;
        end
        return 1'b1;
    endfunction

    // R3: consecutive requests step the horizontal offset with wrap.
    a_r3_x_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |->
            (cand_x_o == (($past(cand_x_o) == XW'(SRCH_W - 1)) ? '0 : $past(cand_x_o) + 1'b1)));

    // R3: the vertical offset advances only when the row wraps.
    a_r3_y_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |->
            (cand_y_o == (($past(cand_x_o) == XW'(SRCH_W - 1)) ? $past(cand_y_o) + 1'b1 : $past(cand_y_o))));

    // R6: a result appears exactly three cycles after its request.
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (sad_vld_o == $past(rd_en_o, 3)));

    // R6: the result carries the index of the candidate requested three cycles earlier.
    a_r6_index: assert property (@(posedge clk) disable iff (!rst_n)
        sad_vld_o |-> (int'(sad_idx_o) == int'($past(cand_y_o, 3)) * int'(SRCH_W) + int'($past(cand_x_o, 3))));

    // R7: done only with the result of the final candidate.
    a_r7_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sad_vld_o && sad_idx_o == IDX_W'(NUM_CAND - 1)));

    // R7: the final candidate's result always carries done.
    a_r7_last_done: assert property (@(posedge clk) disable iff (!rst_n)
        (sad_vld_o && sad_idx_o == IDX_W'(NUM_CAND - 1)) |-> done_o);

    // R8: every lane stays within the largest possible sub-block SAD.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        sad_vld_o |-> lanes_in_range(sad_o));

    // R9: a start during a run never sends the sequence back to offset zero.
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && rd_en_o && !(cand_x_o == XW'(SRCH_W - 1) && cand_y_o == YW'(SRCH_H - 1)))
            |=> (rd_en_o && (cand_x_o != '0 || cand_y_o != '0)));

endmodule

bind sad4x4_array sad4x4_array_chk #(
    .MB_DIM  (MB_DIM),
    .SUB_DIM (SUB_DIM),
    .PIX_W   (PIX_W),
    .SRCH_W  (SRCH_W),
    .SRCH_H  (SRCH_H)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_en_o   (rd_en_o),
    .cand_x_o  (cand_x_o),
    .cand_y_o  (cand_y_o),
    .sad_vld_o (sad_vld_o),
    .sad_idx_o (sad_idx_o),
    .sad_o     (sad_o),
    .done_o    (done_o)
);

// File: tb/sad4x4_array_bench.sv
`timescale 1ns/1ps
// Bench: sweeps every candidate of the window under several pixel patterns.
// It models the search banks and computes each 4x4 SAD arithmetically.
module sad4x4_array_bench;

    localparam int MB   = 16;
    localparam int SUB  = 4;
    localparam int PW   = 8;
    localparam int SW   = 32;
    localparam int SH   = 32;
    localparam int NC   = SW * SH;
    localparam int SPR  = MB / SUB;
    localparam int NSUB = SPR * SPR;
    localparam int SADW = 12;
    localparam int BLKW = MB * MB * PW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [BLKW-1:0] cur_blk_i = '0;
    logic [BLKW-1:0] ref_rows_i = '0;
    logic            rd_en_o;
    logic [4:0]      cand_x_o;
    logic [4:0]      cand_y_o;
    logic            sad_vld_o;
    logic [9:0]      sad_idx_o;
    logic [NSUB*SADW-1:0] sad_o;
    logic            done_o;

    sad4x4_array u_sad4x4_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cur_blk_i  (cur_blk_i),
        .rd_en_o    (rd_en_o),
        .cand_x_o   (cand_x_o),
        .cand_y_o   (cand_y_o),
        .ref_rows_i (ref_rows_i),
        .sad_vld_o  (sad_vld_o),
        .sad_idx_o  (sad_idx_o),
        .sad_o      (sad_o),
        .done_o     (done_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int run_pat = 0;
    bit mon_on = 1'b0;
    int exp_issue = 0;
    int exp_out = 0;
    int done_cnt = 0;
    int cyc = 0;
    int issue_cyc [NC];
    bit prev_rd = 1'b0;
    int prev_x = 0;
    int prev_y = 0;

    function automatic int ref_pix(int pat, int y, int x);
        case (pat)
            0: return (y*29 + x*53 + y*x + 17) % 256;
            1: return 0;
            2: return (y*y + 3*x) % 256;
            default: return (x ^ (y*5)) & 255;
        endcase
    endfunction

    function automatic int cur_pix(int pat, int r, int c);
        case (pat)
            0: return (r*37 + c*11 + 5) % 256;
            1: return 255;
            2: return ref_pix(2, r + 7, c + 21);
            default: return (r*c + 91*pat) % 256;
        endcase
    endfunction

    function automatic logic [BLKW-1:0] build_cur(int pat);
        logic [BLKW-1:0] v;
        for (int r = 0; r < MB; r++)
            for (int c = 0; c < MB; c++)
                v[(r*MB + c)*PW +: PW] = PW'(cur_pix(pat, r, c));
        return v;
    endfunction

    function automatic logic [BLKW-1:0] build_rows(int pat, int y, int x);
        logic [BLKW-1:0] v;
        for (int r = 0; r < MB; r++)
            for (int c = 0; c < MB; c++)
                v[(r*MB + c)*PW +: PW] = PW'(ref_pix(pat, y + r, x + c));
        return v;
    endfunction

    function automatic int exp_lane(int pat, int idx, int s);
        int y, x, br, bc, sum, d;
        y = idx / SW; x = idx % SW; br = s / SPR; bc = s % SPR; sum = 0;
        for (int i = 0; i < SUB; i++)
            for (int j = 0; j < SUB; j++) begin
                d = cur_pix(pat, br*SUB + i, bc*SUB + j) - ref_pix(pat, y + br*SUB + i, x + bc*SUB + j);
                sum += (d < 0) ? -d : d;
            end
        return sum;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Bank model and output monitor, all on the falling edge.
    initial forever begin
        @(negedge clk);
        cyc++;
        // R4: data answers the request seen one cycle earlier
        ref_rows_i = prev_rd ? build_rows(run_pat, prev_y, prev_x) : '0;
        prev_rd = rd_en_o; prev_x = int'(cand_x_o); prev_y = int'(cand_y_o);
        if (mon_on) begin
            if (rd_en_o) begin
                if (exp_issue < NC) begin
                    check(int'(cand_x_o) == exp_issue % SW, "R3", "cand_x", int'(cand_x_o), exp_issue % SW);
                    check(int'(cand_y_o) == exp_issue / SW, "R3", "cand_y", int'(cand_y_o), exp_issue / SW);
                    issue_cyc[exp_issue] = cyc;
                end else begin
                    check(1'b0, "R3", "request beyond 1024", exp_issue, NC - 1);
                end
                exp_issue++;
            end else if (exp_issue > 0 && exp_issue < NC) begin
                check(1'b0, "R3", "gap in requests at count", exp_issue, NC);
            end
            if (sad_vld_o) begin
                int bad_s, bad_a, bad_e;
                bad_s = -1; bad_a = 0; bad_e = 0;
                check(int'(sad_idx_o) == exp_out, "R6", "result index", int'(sad_idx_o), exp_out);
                if (exp_out < NC) begin
                    check(cyc - issue_cyc[exp_out] == 3, "R6", "request-to-result cycles",
                          cyc - issue_cyc[exp_out], 3);
                    for (int s = 0; s < NSUB; s++) begin
                        int a, e;
                        a = int'(sad_o[s*SADW +: SADW]);
                        e = exp_lane(run_pat, exp_out, s);
                        if (a != e && bad_s < 0) begin bad_s = s; bad_a = a; bad_e = e; end
                    end
                    check(bad_s < 0, (run_pat == 1) ? "R8" : "R5", "lane SAD", bad_a, bad_e);
                    if (run_pat == 2 && exp_out == 7*SW + 21)
                        check(sad_o == '0, "R5", "exact match gives zero", int'(sad_o[SADW-1:0]), 0);
                end
                check(done_o == (exp_out == NC - 1), "R7", "done with result", int'(done_o),
                      int'(exp_out == NC - 1));
                exp_out++;
            end else if (done_o) begin
                check(1'b0, "R7", "done without valid", 1, 0);
            end
            if (done_o) done_cnt++;
        end
    end

    task automatic do_run(int pat, bit disturb);
        int w;
        run_pat = pat; exp_issue = 0; exp_out = 0; done_cnt = 0;
        @(negedge clk);
        cur_blk_i = build_cur(pat);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cur_blk_i = build_cur(3);   // R10: input changes after the accepted start
        #1;
        check(rd_en_o == 1'b1, "R2", "request after start", int'(rd_en_o), 1);
        check(cand_x_o == 5'd0 && cand_y_o == 5'd0, "R2", "first offset",
              int'(cand_y_o)*SW + int'(cand_x_o), 0);
        if (disturb) begin
            repeat (200) @(negedge clk);
            start_i = 1'b1;         // R9: start during a run
            cur_blk_i = build_cur(4);
            @(negedge clk);
            start_i = 1'b0;
            cur_blk_i = build_cur(5);
        end
        w = 0;
        while (done_cnt == 0 && w < 3000) begin
            @(negedge clk);
            w++;
        end
        check(w < 3000, "R7", "done reached", w, 1100);
        repeat (6) @(negedge clk);
        check(exp_issue == NC, "R3", "request count", exp_issue, NC);
        check(exp_out == NC, "R6", "result count", exp_out, NC);
        check(done_cnt == 1, "R7", "done pulses", done_cnt, 1);
        check(rd_en_o == 1'b0 && sad_vld_o == 1'b0, "R3", "idle after run",
              int'(rd_en_o) + int'(sad_vld_o), 0);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        // R1: reset state
        check(rd_en_o == 1'b0 && sad_vld_o == 1'b0 && done_o == 1'b0, "R1", "outputs in reset",
              int'(rd_en_o) + int'(sad_vld_o) + int'(done_o), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(rd_en_o == 1'b0 && sad_vld_o == 1'b0 && done_o == 1'b0, "R1", "idle without start",
                  int'(rd_en_o) + int'(sad_vld_o) + int'(done_o), 0);
        end
        mon_on = 1'b1;
        do_run(0, 1'b1);   // mixed pattern, late start and changing input (R9, R10)
        do_run(1, 1'b0);   // largest difference in every lane (R8)
        do_run(2, 1'b0);   // planted exact match (R5)
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule